// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo audio from a three-wire serial link made of a bit clock, a frame clock and a data line. It turns each left/right sample pair into two parallel 24-bit words. A 3-bit format code chooses the framing. The choices are a frame-aligned MSB format, the I2S format with its one-clock MSB delay, and a right-aligned format in which the LSB sits on the final bit clock of each half-frame. Each right-aligned code also fixes the word length.

The receive logic runs on the serial bit clock. It samples data on the rising edge and closes a channel word on the bit-clock edge at which the frame clock changes level. When a right channel closes after a complete left channel, the pair is placed in holding registers and a toggle flag is flipped. The system-clock side passes that toggle through a synchronizer, copies the pair into its output registers and raises a valid strobe for one system clock. The format code is expected to stay static while a stream is running.

Top module: `aud_serial_rx`

## Requirements
- R1: After reset, `smp_valid` is 0 and `smp_left` and `smp_right` are both 0.
- R2: With `fmt_sel` = 3'b000, the frame clock is high during the left half-frame. The MSB of a two's-complement, MSB-first word is sampled on the first rising bit clock after the frame clock changes level. The next 24 bits fill the output from bit 23 down to bit 0.
- R3: With `fmt_sel` = 3'b001 (I2S), the frame clock is low during the left half-frame. The MSB is sampled on the second rising bit clock of the half-frame, and 24 bits are taken from there.
- R4: In the two codes of R2 and R3, bits after the 24th word bit of a half-frame are ignored. Output positions whose bit clock falls outside the half-frame are 0, so a short word comes out MSB-aligned with zeros below it.
- R5: With a right-aligned code, the frame clock is high for left. The LSB is the bit sampled on the last rising bit clock before the frame clock changes level, and earlier bits beyond the word length are ignored. The codes are 3'b010 for 16 bits, 3'b100 for 20 bits, 3'b101 for 18 bits and 3'b011 for 24 bits.
- R6: Right-aligned words shorter than 24 bits are sign-extended to 24 bits.
- R7: Each complete left half-frame followed by a complete right half-frame yields exactly one `smp_valid` pulse, one system clock wide. The pulse comes after the frame-clock change that ends the right half-frame, and it carries both words together. The outputs hold their values between pulses.
- R8: The half-frame that is under way when reset is released is discarded. A right half-frame with no complete left half-frame before it produces no pulse.
- R9: The unassigned codes 3'b110 and 3'b111 receive exactly as 3'b000 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the parallel outputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| ser_bclk | input | 1 | Serial bit clock |
| ser_fclk | input | 1 | Serial frame clock, marks the left or right half-frame |
| ser_data | input | 1 | Serial data, sampled on rising `ser_bclk` |
| fmt_sel | input | 3 | Framing and word-length code |
| smp_left | output | 24 | Left sample of the latest pair |
| smp_right | output | 24 | Right sample of the latest pair |
| smp_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
On a single bit-clock edge, a channel word can close and the first bit of the next word can be captured. This happens whenever half-frames run back to back: the edge that ends the right word also carries the MSB of the next left word in the frame-aligned format. The bench sends consecutive frames with no idle clocks between them and with opposite MSBs. It then checks that the second pair's left word has the right sign bit and that the first pair's right word gained no extra bit. The sign-extension runs put ones into the ignored leading positions, which confirms that stale shift contents never reach the closed word.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [2:0] {
    FMT_MSB_ALIGN = 3'd0,
    FMT_I2S       = 3'd1,
    FMT_RA16      = 3'd2,
    FMT_RA24      = 3'd3,
    FMT_RA20      = 3'd4,
    FMT_RA18      = 3'd5,
    FMT_SPARE6    = 3'd6,
    FMT_SPARE7    = 3'd7
  } fmt_e;

  function automatic logic fmt_is_i2s(input logic [2:0] f);
    return f == FMT_I2S;
  endfunction

  function automatic logic fmt_is_ra(input logic [2:0] f);
    return (f == FMT_RA16) || (f == FMT_RA18) || (f == FMT_RA20) || (f == FMT_RA24);
  endfunction

  function automatic int fmt_ra_width(input logic [2:0] f);
    int w;
    case (f)
      FMT_RA16: w = 16;
      FMT_RA18: w = 18;
      FMT_RA20: w = 20;
      default:  w = 24;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sq;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sq[0] <= 1'b0;
    else         sq[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sq[g] <= 1'b0;
      else         sq[g] <= sq[g-1];
    end
  end

  assign q = sq[STAGES-1];

endmodule

// File: rtl/aud_rx_deframer.sv
module aud_rx_deframer
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 6
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                fclk,
  input  logic                sdat,
  input  logic [2:0]          fmt,
  output logic [SAMPLE_W-1:0] pair_l,
  output logic [SAMPLE_W-1:0] pair_r,
  output logic                pair_tgl
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] WORD_N  = CNT_W'(SAMPLE_W);

  logic                lr_q, lr_n;
  logic                started_q, started_n;
  logic                armed_q, armed_n;
  logic                lseen_q, lseen_n;
  logic [CNT_W-1:0]    idx_q, idx_n;
  logic [SAMPLE_W-1:0] pos_q, pos_n;
  logic [SAMPLE_W-1:0] sh_q, sh_n;
  logic [SAMPLE_W-1:0] left_q, left_n;
  logic [SAMPLE_W-1:0] pl_q, pl_n, pr_q, pr_n;
  logic                tgl_q, tgl_n;

  logic                is_i2s, is_ra, edge_x, in_word, sgn;
  int                  ra_w;
  logic [CNT_W-1:0]    start_pos, rel;
  logic [SAMPLE_W-1:0] ra_ext, done_word;

  // next state
  always_comb begin
    is_i2s    = fmt_is_i2s(fmt);
    is_ra     = fmt_is_ra(fmt);
    ra_w      = fmt_ra_width(fmt);
    edge_x    = started_q && (fclk != lr_q);
    idx_n     = edge_x ? '0 : ((idx_q == CNT_MAX) ? CNT_MAX : idx_q + 1'b1);
    start_pos = is_i2s ? CNT_W'(1) : '0;
    rel       = idx_n - start_pos;
    in_word   = (idx_n >= start_pos) && (rel < WORD_N);

    sgn = 1'b0;
    for (int b = 0; b < SAMPLE_W; b++) begin
      if (b == ra_w - 1) sgn = sh_q[b];
    end
    for (int b = 0; b < SAMPLE_W; b++) begin
      ra_ext[b] = (b < ra_w) ? sh_q[b] : sgn;
    end
    done_word = is_ra ? ra_ext : pos_q;

    pos_n = edge_x ? '0 : pos_q;
    for (int b = 0; b < SAMPLE_W; b++) begin
      if (in_word && (rel == CNT_W'(SAMPLE_W - 1 - b))) pos_n[b] = sdat;
    end
    sh_n      = {sh_q[SAMPLE_W-2:0], sdat};
    lr_n      = fclk;
    started_n = 1'b1;
    armed_n   = armed_q | edge_x;
    lseen_n   = lseen_q;
    left_n    = left_q;
    pl_n      = pl_q;
    pr_n      = pr_q;
    tgl_n     = tgl_q;

    if (edge_x && armed_q) begin
      if (lr_q ^ is_i2s) begin
        left_n  = done_word;
        lseen_n = 1'b1;
      end else if (lseen_q) begin
        pl_n    = left_q;
        pr_n    = done_word;
        tgl_n   = ~tgl_q;
        lseen_n = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q      <= 1'b0;
      started_q <= 1'b0;
      armed_q   <= 1'b0;
      lseen_q   <= 1'b0;
      idx_q     <= '0;
      pos_q     <= '0;
      sh_q      <= '0;
      left_q    <= '0;
      pl_q      <= '0;
      pr_q      <= '0;
      tgl_q     <= 1'b0;
    end else begin
      lr_q      <= lr_n;
      started_q <= started_n;
      armed_q   <= armed_n;
      lseen_q   <= lseen_n;
      idx_q     <= idx_n;
      pos_q     <= pos_n;
      sh_q      <= sh_n;
      left_q    <= left_n;
      pl_q      <= pl_n;
      pr_q      <= pr_n;
      tgl_q     <= tgl_n;
    end
  end

  assign pair_l   = pl_q;
  assign pair_r   = pr_q;
  assign pair_tgl = tgl_q;

  // R7: a new pair is only issued on an edge where the frame clock changed
  p_pair_on_boundary_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    (tgl_q != $past(tgl_q)) |-> $past(started_q && (fclk != lr_q)));

  // R6: a 16-bit right-aligned word reaches the pair sign-extended
  p_ra16_sext_r6: assert property (@(posedge bclk) disable iff (!rst_n)
    ((tgl_q != $past(tgl_q)) && $past(fmt == FMT_RA16))
      |-> ((pr_q[SAMPLE_W-1:15] == '0) || (pr_q[SAMPLE_W-1:15] == '1)));

endmodule

// File: rtl/aud_rx_handoff.sv
module aud_rx_handoff #(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] pair_l,
  input  logic [SAMPLE_W-1:0] pair_r,
  input  logic                pair_tgl,
  output logic [SAMPLE_W-1:0] out_l,
  output logic [SAMPLE_W-1:0] out_r,
  output logic                out_valid
);

  logic                tgl_s;
  logic                seen_q, seen_n;
  logic                vld_q, vld_n;
  logic [SAMPLE_W-1:0] l_q, l_n, r_q, r_n;
  logic                fire;

  aud_rx_sync #(.STAGES(SYNC_STAGES)) i_tgl_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d      (pair_tgl),
    .q      (tgl_s)
  );

  always_comb begin
    fire   = tgl_s ^ seen_q;
    seen_n = tgl_s;
    vld_n  = fire;
    l_n    = fire ? pair_l : l_q;
    r_n    = fire ? pair_r : r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      vld_q  <= 1'b0;
      l_q    <= '0;
      r_q    <= '0;
    end else begin
      seen_q <= seen_n;
      vld_q  <= vld_n;
      l_q    <= l_n;
      r_q    <= r_n;
    end
  end

  assign out_l     = l_q;
  assign out_r     = r_q;
  assign out_valid = vld_q;

  // R7: strobe lasts a single system clock
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: outputs move only together with the strobe
  p_left_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_l));

  p_right_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_r));

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
  parameter int SAMPLE_W    = 24,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sys_clk,
  input  logic                rst_n,
  input  logic                ser_bclk,
  input  logic                ser_fclk,
  input  logic                ser_data,
  input  logic [2:0]          fmt_sel,
  output logic [SAMPLE_W-1:0] smp_left,
  output logic [SAMPLE_W-1:0] smp_right,
  output logic                smp_valid
);

  logic                b_rst_n, s_rst_n;
  logic [SAMPLE_W-1:0] pair_l, pair_r;
  logic                pair_tgl;

  aud_rx_sync #(.STAGES(SYNC_STAGES)) i_rst_bclk (
    .clk    (ser_bclk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (b_rst_n)
  );

  aud_rx_sync #(.STAGES(SYNC_STAGES)) i_rst_sys (
    .clk    (sys_clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (s_rst_n)
  );

  aud_rx_deframer #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) i_deframer (
    .bclk     (ser_bclk),
    .rst_n    (b_rst_n),
    .fclk     (ser_fclk),
    .sdat     (ser_data),
    .fmt      (fmt_sel),
    .pair_l   (pair_l),
    .pair_r   (pair_r),
    .pair_tgl (pair_tgl)
  );

  aud_rx_handoff #(.SAMPLE_W(SAMPLE_W), .SYNC_STAGES(SYNC_STAGES)) i_handoff (
    .clk       (sys_clk),
    .rst_n     (s_rst_n),
    .pair_l    (pair_l),
    .pair_r    (pair_r),
    .pair_tgl  (pair_tgl),
    .out_l     (smp_left),
    .out_r     (smp_right),
    .out_valid (smp_valid)
  );

endmodule

// File: tb/test_aud_serial_rx.sv
`timescale 1ns/1ps
module test_aud_serial_rx;

  logic        sys_clk = 1'b0;
  logic        rst_n, ser_bclk, ser_fclk, ser_data;
  logic [2:0]  fmt_sel;
  logic [23:0] smp_left, smp_right;
  logic        smp_valid;

  int n_chk = 0, n_fail = 0;
  int n_pairs = 0, n_hi = 0;
  logic vprev = 1'b0;
  logic [23:0] got_l [4];
  logic [23:0] got_r [4];

  aud_serial_rx i_aud_serial_rx (
    .sys_clk(sys_clk), .rst_n(rst_n), .ser_bclk(ser_bclk), .ser_fclk(ser_fclk),
    .ser_data(ser_data), .fmt_sel(fmt_sel), .smp_left(smp_left),
    .smp_right(smp_right), .smp_valid(smp_valid)
  );

  always #2 sys_clk = ~sys_clk;

  always @(negedge sys_clk) begin
    if (smp_valid) n_hi++;
    if (smp_valid && !vprev) begin
      if (n_pairs < 4) begin
        got_l[n_pairs] = smp_left;
        got_r[n_pairs] = smp_right;
      end
      n_pairs++;
    end
    vprev = smp_valid;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word(input int kind, input int n, input int w, input logic [23:0] v);
    logic [23:0] r;
    r = '0;
    if (kind == 2) begin
      for (int b = 0; b < 24; b++) r[b] = (b < w) ? v[b] : v[w-1];
    end else begin
      for (int k = 0; k < w; k++)
        if (k < 24 && k + kind < n) r[23-k] = v[w-1-k];
    end
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; ser_bclk = 1'b0; ser_fclk = 1'b0; ser_data = 1'b0;
    #40;
    rst_n = 1'b1;
    #40;
    n_pairs = 0; n_hi = 0;
  endtask

  task automatic send_bit(input logic lr, input logic d);
    ser_fclk = lr; ser_data = d;
    #20 ser_bclk = 1'b1;
    #20 ser_bclk = 1'b0;
  endtask

  // kind: 0 MSB-aligned, 1 I2S, 2 right-aligned
  task automatic send_half(input int kind, input logic lvl, input int n, input int w, input logic [23:0] v);
    for (int i = 0; i < n; i++) begin
      int k;
      logic b;
      if (kind == 2) begin
        k = i - (n - w);
        b = (k >= 0) ? v[w-1-k] : 1'b1;
      end else begin
        k = i - kind;
        b = (k >= 0 && k < w) ? v[w-1-k] : ((k >= 24) ? 1'b1 : 1'b0);
      end
      send_bit(lvl, b);
    end
  endtask

  task automatic run_fmt(input string req, input logic [2:0] code, input int kind, input int n,
                         input int w, input logic [23:0] l0, input logic [23:0] r0,
                         input logic [23:0] l1, input logic [23:0] r1, input int nfr);
    logic lv;
    do_reset();
    fmt_sel = code;
    lv = (kind == 1) ? 1'b0 : 1'b1;
    repeat (4) send_bit(~lv, 1'b0);
    send_half(kind, lv, n, w, l0);
    send_half(kind, ~lv, n, w, r0);
    if (nfr == 2) begin
      send_half(kind, lv, n, w, l1);
      send_half(kind, ~lv, n, w, r1);
    end
    send_bit(lv, 1'b0);
    #200;
    chk(req, "pair count", n_pairs, nfr);
    chk("R7", "valid high cycles", n_hi, nfr);
    chk(req, "left 0", got_l[0], exp_word(kind, n, w, l0));
    chk(req, "right 0", got_r[0], exp_word(kind, n, w, r0));
    if (nfr == 2) begin
      chk(req, "left 1", got_l[1], exp_word(kind, n, w, l1));
      chk(req, "right 1", got_r[1], exp_word(kind, n, w, r1));
    end
  endtask

  task automatic t_reset();
    do_reset();
    fmt_sel = 3'd0;
    #20;
    chk("R1", "valid after reset", smp_valid, 0);
    chk("R1", "left after reset", smp_left, 0);
    chk("R1", "right after reset", smp_right, 0);
  endtask

  task automatic t_msb_align();
    run_fmt("R2", 3'b000, 0, 32, 24, 24'h812345, 24'h7ABCDE, 24'h000001, 24'hFFFFFF, 2);
  endtask

  task automatic t_i2s();
    run_fmt("R3", 3'b001, 1, 32, 24, 24'hC0FFEE, 24'h123456, 24'h7FFFFF, 24'h800000, 2);
  endtask

  task automatic t_short();
    run_fmt("R4", 3'b000, 0, 16, 16, 24'h00A5C3, 24'h005A3C, 24'h0, 24'h0, 1);
    run_fmt("R4", 3'b001, 1, 16, 16, 24'h008001, 24'h00FFFF, 24'h0, 24'h0, 1);
  endtask

  task automatic t_right_align();
    run_fmt("R6", 3'b010, 2, 32, 16, 24'h008765, 24'h001234, 24'h0, 24'h0, 1);
    run_fmt("R6", 3'b100, 2, 32, 20, 24'h09ABCD, 24'h012345, 24'h0, 24'h0, 1);
    run_fmt("R5", 3'b101, 2, 32, 18, 24'h020001, 24'h01FFFF, 24'h0, 24'h0, 1);
    run_fmt("R5", 3'b011, 2, 32, 24, 24'hC00000, 24'h3FFFFF, 24'h0, 24'h0, 1);
  endtask

  task automatic t_spare();
    run_fmt("R9", 3'b110, 0, 32, 24, 24'hABCDEF, 24'h135791, 24'h0, 24'h0, 1);
    run_fmt("R9", 3'b111, 0, 32, 24, 24'h246802, 24'hFEDCBA, 24'h0, 24'h0, 1);
  endtask

  task automatic t_partial();
    do_reset();
    fmt_sel = 3'b000;
    repeat (10) send_bit(1'b1, 1'b1);
    send_half(0, 1'b0, 32, 24, 24'h111111);
    send_half(0, 1'b1, 32, 24, 24'h222222);
    send_half(0, 1'b0, 32, 24, 24'h333333);
    send_bit(1'b1, 1'b0);
    #200;
    chk("R8", "pair count", n_pairs, 1);
    chk("R8", "left", got_l[0], 24'h222222);
    chk("R8", "right", got_r[0], 24'h333333);
    chk("R7", "held left", smp_left, 24'h222222);
  endtask

  initial begin
    fmt_sel = 3'd0;
    t_reset();
    t_msb_align();
    t_i2s();
    t_short();
    t_right_align();
    t_spare();
    t_partial();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule